// File: doc/BRIEF.md
# Wavefront Fetch Arbiter

This block picks, once per cycle, which wavefront slot may launch its next instruction-line fetch. Every slot reports its execution state, whether its line buffer still has a free entry, whether a branch has frozen its fetching, and a completion strobe for a fetch that has come back or been dropped. A slot that passes all gates and is not already waiting in line is appended to an oldest-first ready queue. The head of that queue gets the grant.

A grant sets the slot's fetch-in-flight flag. That flag keeps the slot out of the queue until its completion strobe arrives, so each wavefront has at most one line fetch outstanding. Address translation, the memory request and the returned data all belong to the consumer of the grant.

Top module: `wave_fetch_arb`

## Requirements
- R1: While `rst_n` is low at a clock edge, all in-flight and queued flags are cleared and the ready queue is emptied. From the following cycle no grant is shown until a slot is newly entered.
- R2: A slot can enter the queue only when its 2-bit state field (slot i at bits [2i+1:2i]) holds 1 (running) or 2 (waiting on a counter). The values 0 (idle) and 3 (halted) keep it out.
- R3: A slot can enter the queue only when its `buf_free_i` bit is 1, its `stop_fetch_i` bit is 0 and it has no fetch in flight.
- R4: A slot that passes R2 and R3 and is not queued is entered at a clock edge. A grant is therefore shown in the very next cycle.
- R5: A slot already in the queue is never entered a second time, so it receives one grant per entry.
- R6: At most one slot is granted per cycle. `grant_oh_o` is one-hot and matches `grant_slot_o` when `grant_valid_o` is 1, and it is all-zero when the queue is empty.
- R7: Grants follow entry order, oldest first. Slots entered at the same edge are ordered by ascending slot index.
- R8: At the edge that ends a grant, the granted slot's in-flight flag is set and its queued flag is cleared. The slot cannot re-enter while the flag is set.
- R9: A 1 on `fetch_done_i[i]` clears slot i's in-flight flag at the clock edge. A strobe on a slot with nothing in flight has no effect.
- R10: A queued slot keeps its place and is still granted even if its gating inputs turn false after it was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_state_i | input | 2*NUM_WAVES | Per-slot execution state, 2 bits per slot |
| buf_free_i | input | NUM_WAVES | Per-slot line buffer has a free entry |
| stop_fetch_i | input | NUM_WAVES | Per-slot fetch freeze after a branch |
| fetch_done_i | input | NUM_WAVES | Per-slot strobe: outstanding fetch returned or abandoned |
| grant_valid_o | output | 1 | A slot is granted a fetch this cycle |
| grant_oh_o | output | NUM_WAVES | One-hot grant vector |
| grant_slot_o | output | SLOT_W | Index of the granted slot |

## Verification
Two things can happen in the same cycle. The queue head can be granted, and so removed, while fresh slots are appended behind it. A completion strobe can also clear one slot's in-flight flag while a different slot is being granted. The bench provokes both. It makes many slots eligible together while the queue is already occupied. It also pulses `fetch_done_i` on the cycle that another slot is granted, and on slots that are idle. A behavioural queue model in the bench predicts the grant for every cycle, and any mismatch in valid, index or one-hot vector is judged a failure.

// File: rtl/wave_fetch_pkg.sv
// Package: shared encodings for the wavefront fetch arbiter.
// Assumes a 2-bit state field per slot, supplied by the wavefront controller.
package wave_fetch_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        WS_IDLE    = 2'd0,
        WS_RUN     = 2'd1,
        WS_WAITCNT = 2'd2,
        WS_HALT    = 2'd3
    } wave_state_e;
endpackage

// File: rtl/wfa_slot_elig.sv
// Module: per-slot eligibility test.
// Evaluates the four fetch gates for every slot in parallel; purely combinational.
// Assumes pending_i is the registered in-flight flag of each slot.
module wfa_slot_elig
    import wave_fetch_pkg::*;
#(
    parameter int NUM_WAVES = 8
) (
    input  logic [NUM_WAVES*STATE_W-1:0] state_i,
    input  logic [NUM_WAVES-1:0]         buf_free_i,
    input  logic [NUM_WAVES-1:0]         stop_i,
    input  logic [NUM_WAVES-1:0]         pending_i,
    output logic [NUM_WAVES-1:0]         elig_o
);
    for (genvar g = 0; g < NUM_WAVES; g++) begin : g_slot
        wave_state_e st;
        logic        active;

        assign st = wave_state_e'(state_i[g*STATE_W +: STATE_W]);

        // Purpose: active when running or waiting on a counter.
        always_comb begin
            active = (st == WS_RUN) || (st == WS_WAITCNT);
        end

        assign elig_o[g] = active && buf_free_i[g] && !stop_i[g] && !pending_i[g];
    end
endmodule

// File: rtl/wfa_ready_queue.sv
// Module: oldest-first queue of slot indices.
// Accepts up to NUM_WAVES pushes per cycle (ascending slot order) and one pop.
// Assumes the caller never pushes a slot already held, so occupancy stays <= NUM_WAVES.
module wfa_ready_queue #(
    parameter int NUM_WAVES = 8,
    localparam int SLOT_W = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1,
    localparam int CNT_W  = $clog2(NUM_WAVES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WAVES-1:0] push_vec_i,
    input  logic                 pop_i,
    output logic                 not_empty_o,
    output logic [SLOT_W-1:0]    head_o
);
    logic [SLOT_W-1:0] slot_q [NUM_WAVES];
    logic [SLOT_W-1:0] slot_d [NUM_WAVES];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;

    assign not_empty_o = (cnt_q != '0);
    assign head_o      = slot_q[0];

    // Purpose: shift out the head on pop, then append new slots in index order.
    always_comb begin
        int unsigned wpos;
        for (int i = 0; i < NUM_WAVES; i++) begin
            slot_d[i] = slot_q[i];
        end
        wpos = int'(cnt_q);
        if (pop_i && not_empty_o) begin
            for (int i = 0; i < NUM_WAVES - 1; i++) begin
                slot_d[i] = slot_q[i+1];
            end
            wpos = wpos - 1;
        end
        for (int k = 0; k < NUM_WAVES; k++) begin
            if (push_vec_i[k] && (wpos < NUM_WAVES)) begin
                slot_d[wpos] = SLOT_W'(k);
                wpos = wpos + 1;
            end
        end
        cnt_d = CNT_W'(wpos);
    end

    // Purpose: queue storage and occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < NUM_WAVES; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < NUM_WAVES; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end
endmodule

// File: rtl/wave_fetch_arb.sv
// Module: wavefront fetch arbiter top.
// Enters eligible, unqueued slots into an oldest-first queue and grants the head each cycle.
// Assumes the grant consumer always accepts, and fetch_done_i is pulsed once per finished fetch.
module wave_fetch_arb
    import wave_fetch_pkg::*;
#(
    parameter int NUM_WAVES = 8,
    localparam int SLOT_W = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WAVES*STATE_W-1:0] wave_state_i,
    input  logic [NUM_WAVES-1:0]         buf_free_i,
    input  logic [NUM_WAVES-1:0]         stop_fetch_i,
    input  logic [NUM_WAVES-1:0]         fetch_done_i,
    output logic                         grant_valid_o,
    output logic [NUM_WAVES-1:0]         grant_oh_o,
    output logic [SLOT_W-1:0]            grant_slot_o
);
    logic [NUM_WAVES-1:0] pending_q;
    logic [NUM_WAVES-1:0] queued_q;
    logic [NUM_WAVES-1:0] elig_vec;
    logic [NUM_WAVES-1:0] enq_vec;
    logic                 q_not_empty;
    logic [SLOT_W-1:0]    q_head;

    wfa_slot_elig #(.NUM_WAVES(NUM_WAVES)) elig_i (
        .state_i    (wave_state_i),
        .buf_free_i (buf_free_i),
        .stop_i     (stop_fetch_i),
        .pending_i  (pending_q),
        .elig_o     (elig_vec)
    );

    assign enq_vec = elig_vec & ~queued_q;

    wfa_ready_queue #(.NUM_WAVES(NUM_WAVES)) queue_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_vec_i  (enq_vec),
        .pop_i       (q_not_empty),
        .not_empty_o (q_not_empty),
        .head_o      (q_head)
    );

    // Purpose: decode the queue head into the grant outputs.
    always_comb begin
        grant_valid_o = q_not_empty;
        grant_slot_o  = q_head;
        grant_oh_o    = '0;
        if (q_not_empty) begin
            grant_oh_o[q_head] = 1'b1;
        end
    end

    // Purpose: per-slot queued and in-flight flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            queued_q  <= '0;
            pending_q <= '0;
        end else begin
            queued_q  <= (queued_q | enq_vec) & ~grant_oh_o;
            pending_q <= (pending_q & ~fetch_done_i) | grant_oh_o;
        end
    end
endmodule

// File: rtl/wfa_checker.sv
// Module: property checker for the fetch arbiter, bound to every instance of the top.
// Assumes it sees the top's ports and its internal entry vector.
module wfa_checker #(
    parameter int NUM_WAVES = 8,
    localparam int SLOT_W = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 grant_valid_o,
    input logic [NUM_WAVES-1:0] grant_oh_o,
    input logic [SLOT_W-1:0]    grant_slot_o,
    input logic [NUM_WAVES-1:0] enq_vec
);
    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh_o) && (grant_valid_o == (grant_oh_o != '0)));

    // R6
    grant_index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> grant_oh_o[grant_slot_o]);

    // R8
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |=> !(grant_valid_o && (grant_slot_o == $past(grant_slot_o))));

    // R4
    entry_then_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_vec != '0) |=> grant_valid_o);
endmodule

bind wave_fetch_arb wfa_checker #(.NUM_WAVES(NUM_WAVES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant_valid_o (grant_valid_o),
    .grant_oh_o    (grant_oh_o),
    .grant_slot_o  (grant_slot_o),
    .enq_vec       (enq_vec)
);

// File: tb/wave_fetch_arb_tb_top.sv
// Bench: behavioural queue model of the arbiter, compared every cycle.
module wave_fetch_arb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int SW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] st = '0;
    logic [N-1:0]   bf = '0;
    logic [N-1:0]   stp = '0;
    logic [N-1:0]   dn = '0;
    logic           g_valid;
    logic [N-1:0]   g_oh;
    logic [SW-1:0]  g_slot;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    bit m_pend [N];
    bit m_qd   [N];
    int m_q    [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_fetch_arb #(.NUM_WAVES(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wave_state_i  (st),
        .buf_free_i    (bf),
        .stop_fetch_i  (stp),
        .fetch_done_i  (dn),
        .grant_valid_o (g_valid),
        .grant_oh_o    (g_oh),
        .grant_slot_o  (g_slot)
    );

    function automatic void set_state(int s, int v);
        st[2*s +: 2] = 2'(v);
    endfunction

    // Compare outputs, then advance the model as of the coming edge.
    task automatic step(input string tag);
        bit          ev;
        int          es;
        logic [N-1:0] eoh;
        int          newq [$];
        #1;
        ev  = (m_q.size() != 0);
        es  = ev ? m_q[0] : 0;
        eoh = ev ? (N'(1) << es) : '0;
        checks++;
        if (g_valid !== ev || g_oh !== eoh || (ev && int'(g_slot) != es)) begin
            errors++;
            $display("FAIL %s: valid=%0b slot=%0d oh=%b expected valid=%0b slot=%0d oh=%b",
                     tag, g_valid, g_slot, g_oh, ev, es, eoh);
        end
        if (!rst_n) begin
            m_q.delete();
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0;
                m_qd[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                int sv;
                sv = int'(st[2*i +: 2]);
                if ((sv == 1 || sv == 2) && bf[i] && !stp[i] && !m_pend[i] && !m_qd[i])
                    newq.push_back(i);
            end
            for (int i = 0; i < N; i++) if (dn[i]) m_pend[i] = 0;
            if (m_q.size() != 0) begin
                int h;
                h = m_q.pop_front();
                m_pend[h] = 1;
                m_qd[h] = 0;
            end
            foreach (newq[k]) begin
                m_q.push_back(newq[k]);
                m_qd[newq[k]] = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset with everything eligible
        for (int i = 0; i < N; i++) set_state(i, 1);
        bf = '1;
        run(3, "R1 reset");
        rst_n = 1'b1;
        bf = '0;
        run(2, "R1 idle after reset");

        // R2: state gating, slot i gets state i%4
        for (int i = 0; i < N; i++) set_state(i, i % 4);
        bf = '1;
        run(8, "R2 state gate");
        dn = '1;
        run(1, "R9 done all");
        dn = '0;
        bf = '0;
        run(2, "R2 drain");

        // R3: buffer and stop gates
        for (int i = 0; i < N; i++) set_state(i, 1);
        bf  = 8'b1010_1010;
        stp = 8'b1000_1000;
        run(6, "R3 gates");
        bf = '0; stp = '0;
        dn = '1;
        run(1, "R9 done all");
        dn = '0;

        // R4/R7: simultaneous entry, ascending order; R5: no re-entry while held
        bf = '1;
        run(1, "R4 entry");
        bf = '0;
        run(9, "R7 order");
        run(2, "R5 single grant each");

        // R9: done while another slot granted; done on idle slot ignored
        dn = 8'b0000_0101;
        bf = 8'b0000_0101;
        run(1, "R9 done clears");
        dn = '0;
        bf = 8'b0000_0001;
        run(1, "R8 requeue after done");
        dn = 8'b0000_0010;
        run(1, "R9 done while granting");
        dn = 8'b1111_0000;
        run(1, "R9 done ignored");
        dn = '0; bf = '0;
        run(3, "R8 no reentry while pending");
        dn = '1;
        run(1, "R9 done all");
        dn = '0;

        // R10: entered slots lose eligibility but still granted
        bf = 8'b0111_0000;
        run(1, "R10 entry");
        bf = '0; stp = '1;
        for (int i = 0; i < N; i++) set_state(i, 0);
        run(4, "R10 kept in queue");
        stp = '0;

        // mixed: grant and entry overlap with rotating done
        for (int i = 0; i < N; i++) set_state(i, 2);
        for (int c = 0; c < 40; c++) begin
            bf = N'((c * 37) ^ 8'h5a);
            dn = N'(c * 11) & 8'h3c;
            stp = N'(1) << (c % N);
            step("R7 mixed overlap");
        end
        dn = '0; bf = '0;
        run(10, "R6 drain");

        // R1: reset mid-run with queue occupied
        dn = '1;
        run(1, "R9 done all");
        dn = '0; stp = '0; bf = '1;
        run(2, "R4 refill");
        rst_n = 1'b0;
        run(2, "R1 reset mid-run");
        rst_n = 1'b1; bf = '0;
        run(2, "R1 empty after reset");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule